// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every data beat of one SDRAM burst. A column command presents a start column, a burst length code, a wrap order and a read/write flag. From the next clock on, the block offers one column per beat on a valid/ready stream until the burst completes. The burst can also end early, either through a terminate input or because a fresh column command replaces it.

The column space is `2^COL_W` entries wide, which is one row (page). For bursts of 1, 2, 4 or 8 beats, the address wraps inside the aligned block of that size. Sequential order adds the beat index to the start column. Interleaved order XORs the beat index into it. A full-page burst counts upward across the entire row, wrapping at the row end, and runs until it is terminated. When the single-write option is set, write commands are cut to one beat, while read commands keep the programmed length.

Rules for the beat stream are as follows. The current beat is held while `beat_valid` is high and `beat_ready` is low. The beat is consumed on a clock where both are high. Nothing on the command side waits for `beat_ready`: a command or a terminate takes effect on the next clock whatever the stream state.

Top module: `burst_col_gen`

## Requirements
- R1: The clock after `cmd_start` is sampled high, `beat_valid` is 1 and `beat_col` equals the `cmd_col` that was sampled with it.
- R2: `cmd_bl` encodes the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page; codes 4, 5 and 6 act as 1 beat. `beat_last` is high only on beat L-1 of an L-beat burst. Once that beat is accepted, `beat_valid` drops.
- R3: With `cmd_ilv`=0 and length L from 2 to 8, beat k has the upper column bits of the start column. Its low log2(L) bits equal (start + k) mod L.
- R4: With `cmd_ilv`=1 and length L from 2 to 8, beat k has the upper bits of the start column. Its low log2(L) bits equal the start's low bits XOR k.
- R5: With a full-page burst (`cmd_bl`=7), beat k is (start + k) mod 2^COL_W and `cmd_ilv` has no effect. `beat_last` never rises, and the burst keeps going until `term` or a new command.
- R6: While `beat_valid`=1 and `beat_ready`=0, with no command and no terminate, `beat_col`, `beat_last` and `beat_valid` hold.
- R7: A `cmd_start` during a burst abandons it. The new sequence begins the next clock, and `cmd_start` wins over `term` when both are sampled together.
- R8: `term` sampled high without `cmd_start` makes `beat_valid` 0 the next clock.
- R9: When `wr_single`=1 and `cmd_write`=1, the burst is 1 beat whatever `cmd_bl` says. With `cmd_write`=0, the programmed length applies.
- R10: After reset, `beat_valid` and `beat_last` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Column command strobe |
| cmd_col | input | COL_W | Start column |
| cmd_bl | input | 3 | Burst length code |
| cmd_ilv | input | 1 | 1 selects interleaved order |
| cmd_write | input | 1 | 1 marks the command as a write |
| wr_single | input | 1 | Forces write bursts to one beat |
| term | input | 1 | Burst stop |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | A beat column is offered |
| beat_col | output | COL_W | Column of the current beat |
| beat_last | output | 1 | Current beat is the final one of the burst |

## Verification
On every cycle, the assertions check the beat-stream hold rule and the loading of the start column. They also check that the stream ends after an accepted last beat, that a terminate cancels it, and that one-beat bursts flag their only beat as last. The actual wrap orders, meaning sequential and interleaved columns within the block and full-page row wrap, only appear in the bench's sweeps over every start column, length code and order. The same holds for interruption by a new command.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [2:0] {
    BLC_1    = 3'd0,
    BLC_2    = 3'd1,
    BLC_4    = 3'd2,
    BLC_8    = 3'd3,
    BLC_PAGE = 3'd7
  } blc_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode import burst_col_pkg::*; #(
  parameter int COL_W = 10
) (
  input  logic [2:0]       bl_code,
  input  logic             ilv_req,
  input  logic             is_write,
  input  logic             single_wr,
  output logic [COL_W-1:0] wrap_mask,
  output logic             full_page,
  output logic             ilv
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  always_comb begin
    wrap_mask = '0;
    full_page = 1'b0;
    if (!(is_write && single_wr)) begin
      case (bl_code)
        BLC_2:    wrap_mask = COL_W'(1);
        BLC_4:    wrap_mask = COL_W'(3);
        BLC_8:    wrap_mask = COL_W'(7);
        BLC_PAGE: begin
          wrap_mask = ALL_ONES;
          full_page = 1'b1;
        end
        default:  wrap_mask = '0;
      endcase
    end
    ilv = ilv_req && !full_page;
  end
endmodule

// File: rtl/burst_col_step.sv
module burst_col_step #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  assign sum = base + beat_idx;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = !wrap_mask[i] ? base[i]
                  : (ilv ? (base[i] ^ beat_idx[i]) : sum[i]);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [2:0]       cmd_bl,
  input  logic             cmd_ilv,
  input  logic             cmd_write,
  input  logic             wr_single,
  input  logic             term,
  input  logic             beat_ready,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full, dec_ilv;

  logic             vld_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             last_w;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .bl_code   (cmd_bl),
    .ilv_req   (cmd_ilv),
    .is_write  (cmd_write),
    .single_wr (wr_single),
    .wrap_mask (dec_mask),
    .full_page (dec_full),
    .ilv       (dec_ilv)
  );

  burst_col_step #(.COL_W(COL_W)) u_step (
    .base      (base_q),
    .beat_idx  (idx_q),
    .wrap_mask (mask_q),
    .ilv       (ilv_q),
    .col       (beat_col)
  );

  assign last_w     = vld_q && !full_q && (idx_q == mask_q);
  assign beat_valid = vld_q;
  assign beat_last  = last_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      mask_q <= '0;
    end else if (cmd_start) begin
      vld_q  <= 1'b1;
      full_q <= dec_full;
      ilv_q  <= dec_ilv;
      base_q <= cmd_col;
      idx_q  <= '0;
      mask_q <= dec_mask;
    end else if (term) begin
      vld_q <= 1'b0;
    end else if (vld_q && beat_ready) begin
      idx_q <= idx_q + 1'b1;
      if (last_w) vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic [COL_W-1:0] cmd_col,
  input logic [2:0]       cmd_bl,
  input logic             cmd_write,
  input logic             wr_single,
  input logic             term,
  input logic             beat_ready,
  input logic             beat_valid,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_last
);
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> beat_valid && beat_col == $past(cmd_col));

  p_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last && !cmd_start |=> !beat_valid);

  p_last_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready && !cmd_start && !term |=>
      beat_valid && $stable(beat_col) && $stable(beat_last));

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    term && !cmd_start |=> !beat_valid);

  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && ((cmd_write && wr_single) || cmd_bl == 3'd0) |=> beat_last);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .cmd_col    (cmd_col),
  .cmd_bl     (cmd_bl),
  .cmd_write  (cmd_write),
  .wr_single  (wr_single),
  .term       (term),
  .beat_ready (beat_ready),
  .beat_valid (beat_valid),
  .beat_col   (beat_col),
  .beat_last  (beat_last)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  localparam int W = 5;
  localparam int PAGE = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_ilv = 1'b0, cmd_write = 1'b0, wr_single = 1'b0;
  logic term = 1'b0, beat_ready = 1'b1;
  logic [W-1:0] cmd_col = '0;
  logic [2:0] cmd_bl = '0;
  logic beat_valid, beat_last;
  logic [W-1:0] beat_col;

  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  burst_col_gen #(.COL_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_col(cmd_col),
    .cmd_bl(cmd_bl), .cmd_ilv(cmd_ilv), .cmd_write(cmd_write),
    .wr_single(wr_single), .term(term), .beat_ready(beat_ready),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int blen(input int code, input bit wr, input bit sw);
    if (wr && sw) return 1;
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return PAGE;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int code, input bit ilv, input int k);
    int l, m;
    l = blen(code, 1'b0, 1'b0);
    if (code == 7) return (s + k) % PAGE;
    m = l - 1;
    if (ilv) return (s & ~m) | ((s ^ k) & m);
    return (s & ~m) | ((s + k) & m);
  endfunction

  task automatic issue(input int s, input int code, input bit ilv, input bit wr, input bit sw);
    cmd_start = 1'b1; cmd_col = W'(s); cmd_bl = 3'(code);
    cmd_ilv = ilv; cmd_write = wr; wr_single = sw;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic run_burst(input int s, input int code, input bit ilv,
                           input bit wr, input bit sw, input string req);
    int l;
    l = blen(code, wr, sw);
    @(negedge clk);
    beat_ready = 1'b1;
    issue(s, code, ilv, wr, sw);
    for (int k = 0; k < l; k++) begin
      chk({req, " R1 valid"}, int'(beat_valid), 1);
      chk(req, int'(beat_col), exp_col(s, (wr && sw) ? 0 : code, ilv, k));
      chk("R2 last flag", int'(beat_last), int'(k == l - 1));
      @(negedge clk);
    end
    chk("R2 valid drops", int'(beat_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int idx;
    bit rdy;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", int'(beat_valid), 0);
    chk("R10 reset last", int'(beat_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle valid", int'(beat_valid), 0);

    // Sweep: every start column, codes 0..6, both orders (R2, R3, R4)
    for (int code = 0; code < 7; code++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < PAGE; s++)
          run_burst(s, code, o[0], 1'b0, 1'b0, o[0] ? "R4 interleave col" : "R3 sequential col");

    // R5 full page, order input ignored, wraps across row, ended by term (R8)
    for (int s = 0; s < PAGE; s += 7) begin
      @(negedge clk);
      issue(s, 7, s[0], 1'b0, 1'b0);
      for (int k = 0; k < PAGE + 9; k++) begin
        chk("R5 page col", int'(beat_col), (s + k) % PAGE);
        chk("R5 no last", int'(beat_last), 0);
        chk("R5 still valid", int'(beat_valid), 1);
        @(negedge clk);
      end
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      chk("R8 term clears", int'(beat_valid), 0);
    end

    // R6 back-pressure hold
    @(negedge clk);
    issue(5, 3, 1'b0, 1'b0, 1'b0);
    idx = 0;
    for (int cyc = 0; idx < 8 && cyc < 40; cyc++) begin
      chk("R6 valid", int'(beat_valid), 1);
      chk("R6 col", int'(beat_col), exp_col(5, 3, 1'b0, idx));
      chk("R6 last", int'(beat_last), int'(idx == 7));
      rdy = (cyc % 3) != 0;
      beat_ready = rdy;
      @(negedge clk);
      if (rdy) idx++;
    end
    beat_ready = 1'b1;
    chk("R6 end valid", int'(beat_valid), 0);

    // R8 term mid-burst
    @(negedge clk);
    issue(8, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk("R8 mid-burst stop", int'(beat_valid), 0);

    // R7 interrupt by new command, then command with term together
    @(negedge clk);
    issue(0, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    issue(22, 2, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk("R7 new col", int'(beat_col), exp_col(22, 2, 1'b1, k));
      chk("R7 new last", int'(beat_last), int'(k == 3));
      @(negedge clk);
    end
    chk("R7 new burst ends", int'(beat_valid), 0);
    issue(3, 3, 1'b0, 1'b0, 1'b0);
    term = 1'b1;
    issue(17, 1, 1'b0, 1'b0, 1'b0);
    term = 1'b0;
    chk("R7 start beats term valid", int'(beat_valid), 1);
    chk("R7 start beats term col", int'(beat_col), 17);
    @(negedge clk);
    chk("R7 col beat1", int'(beat_col), 16);
    chk("R7 last beat1", int'(beat_last), 1);
    @(negedge clk);

    // R9 single write vs read
    run_burst(6, 3, 1'b0, 1'b1, 1'b1, "R9 single write col");
    run_burst(6, 3, 1'b0, 1'b0, 1'b1, "R9 read keeps length");
    run_burst(13, 7, 1'b0, 1'b1, 1'b1, "R9 single write page");
    run_burst(9, 2, 1'b1, 1'b1, 1'b0, "R9 write without single");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule